// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

An 8-pin general-purpose I/O port on a simple register bus. Software reaches the pin data through a 256-word window. The word index inside that window is an 8-bit mask, taken from address bits [9:2]. A write changes only the pins whose mask bit is set. A read returns zero for every pin whose mask bit is clear. One bus access can therefore drive or sample any subset of pins, with no read-modify-write sequence.

A per-pin direction register sets each pin as an output or an input. An output pin drives the value held in the data register onto its pad, and its output enable is raised. An input pin is sampled through a two-stage synchronizer. On a read, output pins return the data register contents and input pins return the synchronized pad level. Read data is registered and holds its value between reads.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the data register, the direction register, `rdata_o`, `pad_o` and `pad_oe_o` are all zero, so every pin starts as an input.
- R2: A write with address bit [10] clear is a data write. Mask bit n is address bit n+2. Data bit n takes `wdata_i[n]` where the mask bit is 1 and keeps its value where it is 0. For example, 0xEB written at 0x098 (mask 0x26) turns 0x00 into 0x22 and 0xFF into 0xFB.
- R3: A data read (address bit [10] clear) returns zero in every bit whose mask bit is 0. For example, a read at 0x0C4 (mask 0x31) with input pins at 0xBE returns 0x30.
- R4: The direction register sits at byte address exactly 0x400 and is read and written as a whole byte. Direction bit n set to 1 makes pin n an output and drives `pad_oe_o[n]` high. Data writes leave it unchanged.
- R5: `pad_o` always shows the data register.
- R6: For an input pin, a read returns `pad_i` through two register stages. A read enabled at the first or second rising edge after a pad change returns the old level. A read enabled at the third edge returns the new level.
- R7: For an output pin, a data read returns the data register bit, whatever the level on `pad_i`.
- R8: `rdata_o` updates on the rising edge at which `re_i` is high. It holds its value in every cycle in which `re_i` is low.
- R9: Accesses with address bit [10] set, other than 0x400, are unmapped. Writes there change neither the data nor the direction register. Reads there return 0.
- R10: When a write and a read to the same address fall in the same cycle, the read returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 11 | Byte address of the access |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Registered read data |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables (1 = drive) |
| pad_i | input | 8 | Pad input levels |

## Verification
The assertions assume that `addr_i`, `wdata_i`, `we_i` and `re_i` are known and stable around each rising edge. They assume nothing about when `pad_i` changes, so no property ties read data for input pins to the pads. That path is checked only by the bench, with the synchronizer latency in mind. The stimulus changes every bus input and pad at the falling clock edge. Before each input read it waits at least three edges after a pad change, except in the scenario that probes the latency itself.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } gpio_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int unsigned          NUM_PINS   = 8,
  parameter int unsigned          ADDR_W     = 11,
  parameter logic [ADDR_W-1:0]    DIR_OFFSET = 11'h400
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output gpio_sel_e           sel_o,
  output logic [NUM_PINS-1:0] mask_o
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = MASK_LO + NUM_PINS - 1;

  logic in_window;
  assign in_window = (addr_i[ADDR_W-1:MASK_HI+1] == '0);
  assign mask_o    = addr_i[MASK_HI:MASK_LO];

  always_comb begin
    if (in_window)                sel_o = SEL_DATA;
    else if (addr_i == DIR_OFFSET) sel_o = SEL_DIR;
    else                          sel_o = SEL_NONE;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] async_i,
  output logic [NUM_PINS-1:0] sync_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], async_i[p]};
    end
    assign sync_o[p] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_we_i,
  input  logic                dir_we_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] dir_o
);
  // per-bit enable: the address mask gates each data flop
  for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     bit_q <= 1'b0;
      else if (data_we_i && mask_i[b]) bit_q <= wdata_i[b];
    end
    assign data_o[b] = bit_q;
  end

  logic [NUM_PINS-1:0] dir_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '0;
    else if (dir_we_i) dir_q <= wdata_i;
  end
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned       NUM_PINS   = 8,
  parameter int unsigned       ADDR_W     = 11,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 11'h400
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] pad_i
);
  localparam int unsigned SYNC_STAGES = 2;

  gpio_sel_e           sel;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] data_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] pin_view;
  logic [NUM_PINS-1:0] rd_next;
  logic [NUM_PINS-1:0] rdata_q;

  gpio_addr_dec #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .DIR_OFFSET(DIR_OFFSET)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel),
    .mask_o(mask)
  );

  gpio_in_sync #(
    .NUM_PINS(NUM_PINS),
    .STAGES  (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (pad_sync)
  );

  gpio_port_regs #(
    .NUM_PINS(NUM_PINS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_we_i(we_i && (sel == SEL_DATA)),
    .dir_we_i (we_i && (sel == SEL_DIR)),
    .mask_i   (mask),
    .wdata_i  (wdata_i),
    .data_o   (data_q),
    .dir_o    (dir_q)
  );

  // outputs read back the register, inputs the synchronized pad
  assign pin_view = (dir_q & data_q) | (~dir_q & pad_sync);

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_next = pin_view & mask;
      SEL_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_next;
  end

  assign rdata_o  = rdata_q;
  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned       NUM_PINS   = 8,
  parameter int unsigned       ADDR_W     = 11,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 11'h400
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic                we_i,
  input logic                re_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int unsigned TOP_BIT = NUM_PINS + 2;

  logic                in_win;
  logic                is_dir;
  logic [NUM_PINS-1:0] amask;
  assign in_win = (addr_i[ADDR_W-1:TOP_BIT] == '0);
  assign is_dir = (addr_i == DIR_OFFSET);
  assign amask  = addr_i[TOP_BIT-1:2];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (pad_o == '0 && pad_oe_o == '0 && rdata_o == '0);
    end
  end

  assert_unmasked_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_win) |=> (((pad_o ^ $past(pad_o)) & ~$past(amask)) == '0));

  assert_masked_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_win) |=> ((pad_o & $past(amask)) == ($past(wdata_i) & $past(amask))));

  assert_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_win) |=> ((rdata_o & ~$past(amask)) == '0));

  assert_dir_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_dir) |=> (pad_oe_o == $past(wdata_i)));

  assert_dir_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_win) |=> $stable(pad_oe_o));

  assert_out_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_win) |=>
      (((rdata_o ^ $past(pad_o)) & $past(pad_oe_o) & $past(amask)) == '0));

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_win && !is_dir) |=> ($stable(pad_o) && $stable(pad_oe_o)));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !in_win && !is_dir) |=> (rdata_o == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .DIR_OFFSET(DIR_OFFSET)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o)
);

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [10:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [7:0]  pad_o;
  logic [7:0]  pad_oe_o;
  logic [7:0]  pad_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_mask_port dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .re_i    (re_i),
    .rdata_o (rdata_o),
    .pad_o   (pad_o),
    .pad_oe_o(pad_oe_o),
    .pad_i   (pad_i)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 pad_o", pad_o, 8'h00);
    check("R1 pad_oe_o", pad_oe_o, 8'h00);
    check("R1 rdata_o", rdata_o, 8'h00);
    bus_read(11'h400, r);
    check("R1 dir reg", r, 8'h00);
  endtask

  task automatic t_masked_write();
    bus_write(11'h098, 8'hEB);
    check("R2 from 00", pad_o, 8'h22);
    check("R5 pad_o tracks data", pad_o, 8'h22);
    bus_write(11'h3FC, 8'hFF);
    check("R2 full mask", pad_o, 8'hFF);
    bus_write(11'h098, 8'hEB);
    check("R2 from FF", pad_o, 8'hFB);
    bus_write(11'h000, 8'h00);
    check("R2 empty mask", pad_o, 8'hFB);
    check("R4 dir untouched", pad_oe_o, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    bus_write(11'h400, 8'hFF);
    check("R4 pad_oe_o", pad_oe_o, 8'hFF);
    bus_read(11'h400, r);
    check("R4 dir readback", r, 8'hFF);
  endtask

  task automatic t_output_readback();
    logic [7:0] r;
    pad_i = 8'h00;
    settle();
    bus_read(11'h3FC, r);
    check("R7 outputs full", r, 8'hFB);
    bus_read(11'h0C4, r);
    check("R3 outputs masked", r, 8'h31);
  endtask

  task automatic t_input_read();
    logic [7:0] r;
    bus_write(11'h400, 8'h00);
    pad_i = 8'hBE;
    settle();
    bus_read(11'h0C4, r);
    check("R3 example", r, 8'h30);
    bus_read(11'h3FC, r);
    check("R6 inputs full", r, 8'hBE);
  endtask

  task automatic t_sync_latency();
    @(negedge clk_i);
    pad_i = 8'h41; addr_i = 11'h3FC; re_i = 1'b1;
    @(negedge clk_i);
    check("R6 edge1 old", rdata_o, 8'hBE);
    @(negedge clk_i);
    check("R6 edge2 old", rdata_o, 8'hBE);
    @(negedge clk_i);
    check("R6 edge3 new", rdata_o, 8'h41);
    re_i = 1'b0;
  endtask

  task automatic t_mixed();
    logic [7:0] r;
    bus_write(11'h400, 8'h0F);
    bus_write(11'h3FC, 8'hA5);
    pad_i = 8'h3C;
    settle();
    bus_read(11'h3FC, r);
    check("R7 mixed dir", r, 8'h35);
    bus_read(11'h400, r);
    check("R4 dir 0F", r, 8'h0F);
  endtask

  task automatic t_read_hold();
    pad_i = 8'hFF;
    bus_write(11'h3FC, 8'h00);
    repeat (4) @(negedge clk_i);
    check("R8 hold", rdata_o, 8'h0F);
    bus_write(11'h3FC, 8'hA5);
    pad_i = 8'h3C;
    settle();
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    bus_write(11'h404, 8'hFF);
    bus_write(11'h7FC, 8'hFF);
    bus_write(11'h401, 8'hFF);
    check("R9 data kept", pad_o, 8'hA5);
    check("R9 dir kept", pad_oe_o, 8'h0F);
    bus_read(11'h500, r);
    check("R9 read zero", r, 8'h00);
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    addr_i = 11'h3FC; wdata_i = 8'h5A; we_i = 1'b1; re_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    check("R10 read old", rdata_o, 8'h35);
    check("R10 write done", pad_o, 8'h5A);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_masked_write();
    t_direction();
    t_output_readback();
    t_input_read();
    t_sync_latency();
    t_mixed();
    t_read_hold();
    t_unmapped();
    t_same_cycle();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule